// File: doc/BRIEF.md
# Memory Access Fault Checker

This block decides whether a memory access may go ahead. The access is presented for one cycle with its address, its size and an instruction-fetch flag. The alignment check runs at once, whether or not translation is enabled. A misaligned data access is aborted straight away, and that ends the check for that access.

If the access is aligned and translation is enabled, the block waits for the first-level descriptor to come back from the table walker. When the descriptor's valid strobe arrives, the block checks the descriptor's type bits for validity. It then uses the descriptor's four-bit domain index to pick one two-bit field of the domain access control word. The result says one of three things: the access faults, the access needs a permission check (client domain), or the access passes (manager domain).

Verdicts are registered and held until the next verdict. The table walk and the decoding of permission bits are done elsewhere.

Top module: `access_fault_chk`

## Requirements
- R1: With `align_en` high, a data access of size word (`acc_size` = 2'b10) whose `acc_addr[1:0]` is not 2'b00 gives fault code 3'b001 (alignment) and `abort` high.
- R2: With `align_en` high, a data access of size halfword (`acc_size` = 2'b01) with `acc_addr[0]` set gives fault code 3'b001.
- R3: An instruction fetch (`acc_ifetch` high) or a byte access (`acc_size` = 2'b00) never gives an alignment fault. With `align_en` low, no access gives one.
- R4: The alignment check works the same with `mmu_en` low or high. With `mmu_en` low, a translation or domain fault (codes 3'b010, 3'b100, 3'b101) is never reported, and an aligned access gives code 3'b000 with no descriptor needed.
- R5: After an alignment fault, a descriptor strobe for that access is ignored. Code 3'b001 stays on the outputs and `perm_req` stays low.
- R6: A descriptor whose bits [1:0] are 2'b00 gives fault code 3'b010 (translation). This check comes before the domain check.
- R7: Descriptor bits [8:5] give a domain index n, which selects `dacr[2n+1:2n]`. A value of 2'b00 (no access) or 2'b10 (reserved) gives a domain fault. The code is 3'b100 for a section descriptor (type 2'b10) and 3'b101 for a page descriptor (type 2'b01 or 2'b11).
- R8: A domain value of 2'b01 (client) gives code 3'b000 with `perm_req` high. A value of 2'b11 (manager) gives code 3'b000 with `perm_req` low.
- R9: Verdicts appear on the outputs one clock edge after the access, or after the descriptor strobe if one is needed. They hold until the next verdict. `abort` is high exactly when the fault code is not 3'b000, and `perm_req` is never high together with `abort`.
- R10: After reset, `abort` is low, the fault code is 3'b000 and `perm_req` is low.
- R11: A descriptor strobe that arrives while no access is waiting for a descriptor leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| align_en | input | 1 | Alignment checking enabled |
| mmu_en | input | 1 | Translation enabled |
| desc_valid | input | 1 | First-level descriptor returned this cycle |
| desc | input | 32 | First-level descriptor |
| dacr | input | 32 | Sixteen two-bit domain access fields |
| abort | output | 1 | Access aborted |
| fault_code | output | 3 | Fault type code |
| perm_req | output | 1 | Client domain: permission check needed |

## Verification
The assertions check on every cycle the alignment outcomes for word, byte and fetch accesses. They also check that no translation or domain code appears after an access with translation disabled, that `abort` always matches a nonzero fault code and never appears with `perm_req`, and that a stray descriptor strobe leaves the fault code unchanged. Other behaviour can only be shown by the bench's scenarios. This covers the domain lookup through the descriptor's index into the right field of the control word, the section/page split of domain faults, translation priority over domain faults, the client and manager outcomes, and the discarding of a descriptor after an alignment abort.

// File: rtl/mmu_flt_pkg.sv
package mmu_flt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    typedef enum logic [2:0] {
        FC_NONE      = 3'b000,
        FC_ALIGN     = 3'b001,
        FC_SEC_XLAT  = 3'b010,
        FC_PAGE_XLAT = 3'b011,
        FC_SEC_DOM   = 3'b100,
        FC_PAGE_DOM  = 3'b101
    } fault_e;

    typedef enum logic [1:0] {
        DOM_NOACC  = 2'b00,
        DOM_CLIENT = 2'b01,
        DOM_RSVD   = 2'b10,
        DOM_MGR    = 2'b11
    } dom_e;

    typedef struct packed {
        logic   abort;
        fault_e code;
        logic   perm_req;
    } verdict_t;

    localparam verdict_t VERDICT_CLEAR = '{abort: 1'b0, code: FC_NONE, perm_req: 1'b0};

    // Low address bits that must be zero for an access of the given size
    function automatic logic [1:0] align_mask(input logic [1:0] size);
        case (size)
            SZ_WORD: return 2'b11;
            SZ_HALF: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/align_chk.sv
module align_chk
    import mmu_flt_pkg::*;
(
    input  logic [1:0] addr_lsb,
    input  logic [1:0] size,
    input  logic       ifetch,
    input  logic       enable,
    output logic       misaligned
);
    always_comb begin
        misaligned = enable && !ifetch && ((addr_lsb & align_mask(size)) != 2'b00);
    end
endmodule

// File: rtl/dom_lookup.sv
module dom_lookup #(
    parameter int NUM_DOM = 16,
    parameter int DOM_W   = 2,
    localparam int IDX_W  = $clog2(NUM_DOM)
) (
    input  logic [NUM_DOM*DOM_W-1:0] ctrl_word,
    input  logic [IDX_W-1:0]         idx,
    output logic [DOM_W-1:0]         field
);
    logic [DOM_W-1:0] slices [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_slice
        assign slices[g] = ctrl_word[g*DOM_W +: DOM_W];
    end

    assign field = slices[idx];
endmodule

// File: rtl/desc_judge.sv
module desc_judge
    import mmu_flt_pkg::*;
(
    input  logic [1:0] desc_type,
    input  logic [1:0] dom_field,
    output verdict_t   verdict
);
    logic is_section;
    dom_e dom;

    always_comb begin
        is_section = (desc_type == 2'b10);
        dom        = dom_e'(dom_field);
        verdict    = VERDICT_CLEAR;
        if (desc_type == 2'b00) begin
            verdict.abort = 1'b1;
            verdict.code  = FC_SEC_XLAT;
        end else begin
            case (dom)
                DOM_NOACC, DOM_RSVD: begin
                    verdict.abort = 1'b1;
                    verdict.code  = is_section ? FC_SEC_DOM : FC_PAGE_DOM;
                end
                DOM_CLIENT: verdict.perm_req = 1'b1;
                default:    verdict = VERDICT_CLEAR;
            endcase
        end
    end
endmodule

// File: rtl/access_fault_chk.sv
module access_fault_chk
    import mmu_flt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DESC_W   = 32,
    parameter int NUM_DOM  = 16,
    parameter int DOM_LSB  = 5,
    localparam int DOM_W   = 2,
    localparam int IDX_W   = $clog2(NUM_DOM),
    localparam int DACR_W  = NUM_DOM * DOM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_ifetch,
    input  logic              align_en,
    input  logic              mmu_en,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc,
    input  logic [DACR_W-1:0] dacr,
    output logic              abort,
    output logic [2:0]        fault_code,
    output logic              perm_req
);
    logic             misaligned;
    logic [DOM_W-1:0] dom_field;
    verdict_t         desc_verdict;
    verdict_t         verdict_q;
    logic             waiting;

    align_chk u_align (
        .addr_lsb  (acc_addr[1:0]),
        .size      (acc_size),
        .ifetch    (acc_ifetch),
        .enable    (align_en),
        .misaligned(misaligned)
    );

    dom_lookup #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_dom (
        .ctrl_word(dacr),
        .idx      (desc[DOM_LSB +: IDX_W]),
        .field    (dom_field)
    );

    desc_judge u_judge (
        .desc_type(desc[1:0]),
        .dom_field(dom_field),
        .verdict  (desc_verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= VERDICT_CLEAR;
            waiting   <= 1'b0;
        end else if (acc_valid) begin
            if (misaligned) begin
                verdict_q <= '{abort: 1'b1, code: FC_ALIGN, perm_req: 1'b0};
                waiting   <= 1'b0;
            end else begin
                verdict_q <= VERDICT_CLEAR;
                waiting   <= mmu_en;
            end
        end else if (desc_valid && waiting) begin
            verdict_q <= desc_verdict;
            waiting   <= 1'b0;
        end
    end

    assign abort      = verdict_q.abort;
    assign fault_code = verdict_q.code;
    assign perm_req   = verdict_q.perm_req;
endmodule

// File: rtl/access_fault_chk_sva.sv
module access_fault_chk_sva (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic [1:0] acc_lsb,
    input logic [1:0] acc_size,
    input logic       acc_ifetch,
    input logic       align_en,
    input logic       mmu_en,
    input logic       desc_valid,
    input logic       waiting,
    input logic       abort,
    input logic [2:0] fault_code,
    input logic       perm_req
);
    a_r1_word_misalign: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && align_en && !acc_ifetch && acc_size == 2'b10 && acc_lsb != 2'b00)
        |=> (fault_code == 3'b001 && abort));

    a_r3_no_align_fetch_byte: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_ifetch || acc_size == 2'b00 || !align_en))
        |=> (fault_code != 3'b001));

    a_r4_mmu_off_no_xlat: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !mmu_en) |=> (fault_code == 3'b000 || fault_code == 3'b001));

    a_r9_abort_matches_code: assert property (@(posedge clk) disable iff (rst)
        abort == (fault_code != 3'b000));

    a_r9_perm_excl_abort: assert property (@(posedge clk) disable iff (rst)
        perm_req |-> !abort);

    a_r11_stray_desc: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !waiting && !acc_valid) |=> ($stable(fault_code) && $stable(perm_req)));
endmodule

bind access_fault_chk access_fault_chk_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_lsb   (acc_addr[1:0]),
    .acc_size  (acc_size),
    .acc_ifetch(acc_ifetch),
    .align_en  (align_en),
    .mmu_en    (mmu_en),
    .desc_valid(desc_valid),
    .waiting   (waiting),
    .abort     (abort),
    .fault_code(fault_code),
    .perm_req  (perm_req)
);

// File: tb/access_fault_chk_test.sv
`timescale 1ns/1ps
module access_fault_chk_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_ifetch, align_en, mmu_en, desc_valid;
    logic [31:0] acc_addr, desc, dacr;
    logic [1:0]  acc_size;
    logic        abort, perm_req;
    logic [2:0]  fault_code;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    access_fault_chk uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_ifetch(acc_ifetch), .align_en(align_en),
        .mmu_en(mmu_en), .desc_valid(desc_valid), .desc(desc), .dacr(dacr),
        .abort(abort), .fault_code(fault_code), .perm_req(perm_req)
    );

    // Domains: d0 client, d1 manager, d2 no access, d3 reserved, d15 manager
    localparam logic [31:0] DACR_VAL = 32'hC000_008D;

    typedef struct packed {
        logic [3:0]  req;
        logic        mmu;
        logic        aen;
        logic        ifx;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] dsc;
        logic [2:0]  code;
        logic        perm;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{4'd1,  1'b1, 1'b1, 1'b0, 2'b10, 32'h1002, 32'h002, 3'd1, 1'b0}, // R1 word misaligned
        '{4'd2,  1'b1, 1'b1, 1'b0, 2'b01, 32'h1001, 32'h002, 3'd1, 1'b0}, // R2 half misaligned
        '{4'd8,  1'b1, 1'b1, 1'b0, 2'b01, 32'h1002, 32'h022, 3'd0, 1'b0}, // R8 manager d1
        '{4'd3,  1'b1, 1'b1, 1'b1, 2'b10, 32'h1003, 32'h002, 3'd0, 1'b1}, // R3 fetch, client d0
        '{4'd7,  1'b1, 1'b1, 1'b0, 2'b00, 32'h1003, 32'h042, 3'd4, 1'b0}, // R7 byte, section no-access
        '{4'd4,  1'b0, 1'b1, 1'b0, 2'b10, 32'h2001, 32'h000, 3'd1, 1'b0}, // R4 align with MMU off
        '{4'd4,  1'b0, 1'b1, 1'b0, 2'b10, 32'h2000, 32'h000, 3'd0, 1'b0}, // R4 MMU off clean
        '{4'd6,  1'b1, 1'b0, 1'b0, 2'b10, 32'h3003, 32'h060, 3'd2, 1'b0}, // R6 invalid beats reserved dom
        '{4'd7,  1'b1, 1'b1, 1'b0, 2'b10, 32'h3000, 32'h063, 3'd5, 1'b0}, // R7 page reserved d3
        '{4'd7,  1'b1, 1'b1, 1'b0, 2'b10, 32'h3000, 32'h041, 3'd5, 1'b0}, // R7 page no-access d2
        '{4'd7,  1'b1, 1'b1, 1'b0, 2'b10, 32'h3000, 32'h062, 3'd4, 1'b0}, // R7 section reserved d3
        '{4'd8,  1'b1, 1'b1, 1'b0, 2'b10, 32'h3000, 32'h1E2, 3'd0, 1'b0}, // R8 manager d15
        '{4'd8,  1'b1, 1'b1, 1'b0, 2'b01, 32'h3000, 32'h001, 3'd0, 1'b1}  // R8 client page d0
    };

    task automatic chk(input string req, input logic [2:0] ec, input logic ep);
        logic ea;
        ea = (ec != 3'd0);
        n_chk++;
        if (fault_code !== ec || perm_req !== ep || abort !== ea) begin
            n_err++;
            $display("FAIL %s: code=%0d abort=%0b perm=%0b expected code=%0d abort=%0b perm=%0b",
                     req, fault_code, abort, perm_req, ec, ea, ep);
        end
    endtask

    task automatic present(input logic m, input logic a, input logic f,
                           input logic [1:0] s, input logic [31:0] ad);
        @(negedge clk);
        mmu_en = m; align_en = a; acc_ifetch = f; acc_size = s; acc_addr = ad;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic strobe_desc(input logic [31:0] d);
        @(negedge clk);
        desc = d; desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0; desc = 32'h0;
    endtask

    initial begin
        #(20 * 50000);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_ifetch = 1'b0; align_en = 1'b0;
        mmu_en = 1'b0; desc_valid = 1'b0; acc_addr = '0; desc = '0;
        acc_size = 2'b00; dacr = DACR_VAL;
        repeat (3) @(negedge clk);
        chk("R10", 3'd0, 1'b0);
        rst = 1'b0;

        // Table walk: a descriptor follows when translation is on and the access is aligned (R9 timing)
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VT[i].req, i);
            present(VT[i].mmu, VT[i].aen, VT[i].ifx, VT[i].sz, VT[i].addr);
            if (VT[i].mmu && VT[i].code != 3'd1) begin
                chk("R9 pending", 3'd0, 1'b0);
                strobe_desc(VT[i].dsc);
            end
            chk(tag, VT[i].code, VT[i].perm);
        end

        // R5: descriptor after an alignment abort is discarded
        present(1'b1, 1'b1, 1'b0, 2'b10, 32'h4001);
        strobe_desc(32'h001);
        chk("R5", 3'd1, 1'b0);

        // R11: stray descriptor with nothing pending keeps the last verdict
        present(1'b1, 1'b1, 1'b0, 2'b10, 32'h4000);
        strobe_desc(32'h063);
        chk("R11 setup", 3'd5, 1'b0);
        strobe_desc(32'h001);
        chk("R11", 3'd5, 1'b0);

        // R3: alignment check disabled, misaligned word proceeds to the domain result
        present(1'b1, 1'b0, 1'b0, 2'b10, 32'h5003);
        strobe_desc(32'h002);
        chk("R3 align off", 3'd0, 1'b1);

        // R9: verdict holds across idle cycles
        repeat (4) @(negedge clk);
        chk("R9 hold", 3'd0, 1'b1);

        // R10: reset clears a held fault
        present(1'b0, 1'b1, 1'b0, 2'b01, 32'h6001);
        chk("R2 pre-reset", 3'd1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 after fault", 3'd0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule